// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the raster timing for an LCD panel: a horizontal sync, a vertical sync, a display-enable strobe, a one-cycle frame-start pulse, and the pixel and line position the raster is at. All timing is set at run time through a small write port. Each axis takes four values: the total length, the number of displayed positions, the absolute position where sync begins, and how long sync lasts. The sync position is measured from the start of the line or frame, so it already includes the visible area, any border and the front porch. No separate porch fields exist.

Writes go to a shadow set. The shadow set is copied into the working set only at the frame wrap, so every frame runs on one consistent timing. Both sync outputs have a selectable polarity, and both come out of reset active-low. All outputs are registered and aligned: in any cycle, `de`, `hsync`, `vsync` and `frame_start` describe the position shown on `pixel_x` and `line_y`.

Top module: `lcd_sync_gen`

## Requirements
- R1: While `rst` is high, `pixel_x` and `line_y` are 0, `de` and `frame_start` are 0, and `hsync` and `vsync` are 1, which is inactive at the reset polarity.
- R2: `pixel_x` steps by one each clock. It returns to 0 after reaching the horizontal total minus one. The horizontal total is written at address 0.
- R3: `line_y` steps by one in the cycle where `pixel_x` returns to 0. It returns to 0 after the vertical total minus one. The vertical total is written at address 4.
- R4: `de` is 1 exactly when `pixel_x` is below the horizontal display count (address 1) and `line_y` is below the vertical display count (address 5).
- R5: `hsync` is asserted for pixel positions from the horizontal sync position (address 2) up to, but not including, that position plus the horizontal sync width (address 3). A width of 0 gives no pulse.
- R6: `vsync` is asserted for every pixel of the lines from the vertical sync position (address 6) up to, but not including, that position plus the vertical sync width (address 7). A width of 0 gives no pulse.
- R7: When a sync position plus its width goes past the total, the pulse ends at the wrap. Position 0 of the next line or frame is not in sync unless the sync position is 0.
- R8: Address 8 sets polarity. Bit 0 is for `hsync` and bit 1 is for `vsync`. A bit value of 1 makes that output high while asserted, and 0 makes it low while asserted. Both bits are 0 after reset.
- R9: A write takes effect at the first frame start after it. The frame in progress finishes on the timing it began with.
- R10: `frame_start` is 1 for exactly the cycles in which `pixel_x` and `line_y` are both 0. The first pulse comes in the cycle after the first clock edge after reset is released.
- R11: Writes to addresses 9 to 15 change no timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 12 | Register write value |
| hsync | output | 1 | Horizontal sync, polarity per R8 |
| vsync | output | 1 | Vertical sync, polarity per R8 |
| de | output | 1 | Display enable |
| frame_start | output | 1 | Frame start pulse at position (0,0) |
| pixel_x | output | 12 | Current pixel position in the line |
| line_y | output | 12 | Current line position in the frame |

## Verification
Every output is loaded in the same clock edge as the counters that feed it. A position and its strobes therefore change together, one edge after the state that produces them. A written value affects nothing until the first frame wrap after the write edge. The bench drives writes and reset at the falling edge and samples every output at the falling edge. It first locks onto a `frame_start` pulse. From there it derives the expected position of each later cycle from the programmed totals alone. Each frame is checked against the timing that was in force when that frame began.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

    parameter int unsigned LCD_CW = 12;
    parameter int unsigned LCD_AW = 4;
    localparam int unsigned LCD_NUM_AXES = 2;

    typedef logic [LCD_CW-1:0] lcd_cnt_t;
    typedef logic [LCD_AW-1:0] lcd_addr_t;

    // one axis of timing: all positions counted from the start of the axis
    typedef struct packed {
        lcd_cnt_t total;
        lcd_cnt_t disp;
        lcd_cnt_t spos;
        lcd_cnt_t swidth;
        logic     pol;     // 1: asserted high
    } lcd_axis_cfg_t;

    typedef struct packed {
        lcd_axis_cfg_t h;
        lcd_axis_cfg_t v;
    } lcd_cfg_t;

    localparam lcd_addr_t REG_HTOT = lcd_addr_t'(0);
    localparam lcd_addr_t REG_HDSP = lcd_addr_t'(1);
    localparam lcd_addr_t REG_HSPO = lcd_addr_t'(2);
    localparam lcd_addr_t REG_HSWD = lcd_addr_t'(3);
    localparam lcd_addr_t REG_VTOT = lcd_addr_t'(4);
    localparam lcd_addr_t REG_VDSP = lcd_addr_t'(5);
    localparam lcd_addr_t REG_VSPO = lcd_addr_t'(6);
    localparam lcd_addr_t REG_VSWD = lcd_addr_t'(7);
    localparam lcd_addr_t REG_POL  = lcd_addr_t'(8);

endpackage

// File: rtl/lcd_timing_regs.sv
module lcd_timing_regs
    import lcd_timing_pkg::*;
#(
    parameter lcd_cfg_t RST_CFG = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  lcd_addr_t wr_addr,
    input  lcd_cnt_t  wr_data,
    input  logic      load,
    output lcd_cfg_t  act_q,
    output lcd_cfg_t  act_d
);

    typedef struct packed {
        lcd_cfg_t shadow;
        lcd_cfg_t act;
    } bank_t;

    bank_t bank_d, bank_q;

    // only two bits of the data are meaningful for the polarity register
    logic unused_pol_bits;
    assign unused_pol_bits = ^wr_data[LCD_CW-1:2];

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (wr_addr)
                REG_HTOT: bank_d.shadow.h.total  = wr_data;
                REG_HDSP: bank_d.shadow.h.disp   = wr_data;
                REG_HSPO: bank_d.shadow.h.spos   = wr_data;
                REG_HSWD: bank_d.shadow.h.swidth = wr_data;
                REG_VTOT: bank_d.shadow.v.total  = wr_data;
                REG_VDSP: bank_d.shadow.v.disp   = wr_data;
                REG_VSPO: bank_d.shadow.v.spos   = wr_data;
                REG_VSWD: bank_d.shadow.v.swidth = wr_data;
                REG_POL: begin
                    bank_d.shadow.h.pol = wr_data[0];
                    bank_d.shadow.v.pol = wr_data[1];
                end
                default: ;
            endcase
        end
        // the working set takes the pre-write shadow at the frame wrap
        if (load) begin
            bank_d.act = bank_q.shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '{shadow: RST_CFG, act: RST_CFG};
        end else begin
            bank_q <= bank_d;
        end
    end

    assign act_q = bank_q.act;
    assign act_d = bank_d.act;

endmodule

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr
    import lcd_timing_pkg::*;
#(
    parameter lcd_cnt_t RST_VAL = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     adv_i,
    input  lcd_cnt_t total_i,
    output lcd_cnt_t cnt_q,
    output lcd_cnt_t cnt_d,
    output logic     wrap_o
);

    localparam int unsigned EXT_W = LCD_CW + 1;

    logic [EXT_W-1:0] nxt_ext;

    always_comb begin
        nxt_ext = {1'b0, cnt_q} + EXT_W'(1);
        // ">=" keeps the counter bounded even for totals of 0 or 1
        wrap_o  = adv_i && (nxt_ext >= {1'b0, total_i});
        cnt_d   = cnt_q;
        if (adv_i) begin
            cnt_d = wrap_o ? '0 : nxt_ext[LCD_CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RST_VAL;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lcd_axis_decode.sv
module lcd_axis_decode
    import lcd_timing_pkg::*;
(
    input  lcd_cnt_t      pos_i,
    input  lcd_axis_cfg_t cfg_i,
    output logic          vis_o,
    output logic          sync_o
);

    lcd_cnt_t off;

    always_comb begin
        off    = pos_i - cfg_i.spos;
        vis_o  = pos_i < cfg_i.disp;
        // pos_i never reaches total, so an over-long pulse ends at the wrap
        sync_o = (pos_i >= cfg_i.spos) && (off < cfg_i.swidth);
    end

endmodule

// File: rtl/lcd_sync_out.sv
module lcd_sync_out
    import lcd_timing_pkg::*;
#(
    parameter logic RST_HPOL = 1'b0,
    parameter logic RST_VPOL = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  lcd_cnt_t x_i,
    input  lcd_cnt_t y_i,
    input  logic     h_vis_i,
    input  logic     v_vis_i,
    input  logic     h_sync_i,
    input  logic     v_sync_i,
    input  logic     h_pol_i,
    input  logic     v_pol_i,
    output logic     hsync,
    output logic     vsync,
    output logic     de,
    output logic     frame_start,
    output lcd_cnt_t pixel_x,
    output lcd_cnt_t line_y
);

    typedef struct packed {
        lcd_cnt_t x;
        lcd_cnt_t y;
        logic     de;
        logic     hs;
        logic     vs;
        logic     fs;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d.x  = x_i;
        out_d.y  = y_i;
        out_d.de = h_vis_i && v_vis_i;
        out_d.hs = h_pol_i ? h_sync_i : !h_sync_i;
        out_d.vs = v_pol_i ? v_sync_i : !v_sync_i;
        out_d.fs = (x_i == '0) && (y_i == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '{x: '0, y: '0, de: 1'b0, hs: !RST_HPOL, vs: !RST_VPOL, fs: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign pixel_x     = out_q.x;
    assign line_y      = out_q.y;
    assign de          = out_q.de;
    assign hsync       = out_q.hs;
    assign vsync       = out_q.vs;
    assign frame_start = out_q.fs;

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcd_timing_pkg::*;
#(
    parameter lcd_cnt_t H_TOTAL_RST = lcd_cnt_t'(20),
    parameter lcd_cnt_t H_DISP_RST  = lcd_cnt_t'(12),
    parameter lcd_cnt_t H_SPOS_RST  = lcd_cnt_t'(15),
    parameter lcd_cnt_t H_SWID_RST  = lcd_cnt_t'(3),
    parameter lcd_cnt_t V_TOTAL_RST = lcd_cnt_t'(8),
    parameter lcd_cnt_t V_DISP_RST  = lcd_cnt_t'(5),
    parameter lcd_cnt_t V_SPOS_RST  = lcd_cnt_t'(6),
    parameter lcd_cnt_t V_SWID_RST  = lcd_cnt_t'(1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LCD_AW-1:0] wr_addr,
    input  logic [LCD_CW-1:0] wr_data,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              frame_start,
    output logic [LCD_CW-1:0] pixel_x,
    output logic [LCD_CW-1:0] line_y
);

    localparam lcd_cfg_t RST_CFG = '{
        h: '{total: H_TOTAL_RST, disp: H_DISP_RST, spos: H_SPOS_RST,
             swidth: H_SWID_RST, pol: 1'b0},
        v: '{total: V_TOTAL_RST, disp: V_DISP_RST, spos: V_SPOS_RST,
             swidth: V_SWID_RST, pol: 1'b0}
    };

    lcd_cfg_t      act_q, act_d;
    lcd_axis_cfg_t cur_cfg [LCD_NUM_AXES];
    lcd_axis_cfg_t nxt_cfg [LCD_NUM_AXES];
    lcd_cnt_t      pos_q   [LCD_NUM_AXES];
    lcd_cnt_t      pos_d   [LCD_NUM_AXES];
    logic          adv     [LCD_NUM_AXES];
    logic          wrap    [LCD_NUM_AXES];
    logic          vis     [LCD_NUM_AXES];
    logic          syn     [LCD_NUM_AXES];
    logic          frame_wrap;

    assign cur_cfg[0] = act_q.h;
    assign cur_cfg[1] = act_q.v;
    assign nxt_cfg[0] = act_d.h;
    assign nxt_cfg[1] = act_d.v;

    // lines advance when the pixel counter wraps
    assign adv[0]     = 1'b1;
    assign adv[1]     = wrap[0];
    assign frame_wrap = wrap[0] && wrap[1];

    lcd_timing_regs #(
        .RST_CFG (RST_CFG)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (frame_wrap),
        .act_q   (act_q),
        .act_d   (act_d)
    );

    for (genvar a = 0; a < LCD_NUM_AXES; a++) begin : g_axis
        // counters start on their last position so the first edge opens a frame
        localparam lcd_cnt_t CTR_RST = (a == 0) ? H_TOTAL_RST - lcd_cnt_t'(1)
                                                : V_TOTAL_RST - lcd_cnt_t'(1);

        lcd_axis_ctr #(
            .RST_VAL (CTR_RST)
        ) u_ctr (
            .clk     (clk),
            .rst     (rst),
            .adv_i   (adv[a]),
            .total_i (cur_cfg[a].total),
            .cnt_q   (pos_q[a]),
            .cnt_d   (pos_d[a]),
            .wrap_o  (wrap[a])
        );

        // decode the next position against the set that will be active then
        lcd_axis_decode u_dec (
            .pos_i  (pos_d[a]),
            .cfg_i  (nxt_cfg[a]),
            .vis_o  (vis[a]),
            .sync_o (syn[a])
        );
    end

    lcd_sync_out #(
        .RST_HPOL (RST_CFG.h.pol),
        .RST_VPOL (RST_CFG.v.pol)
    ) u_out (
        .clk         (clk),
        .rst         (rst),
        .x_i         (pos_d[0]),
        .y_i         (pos_d[1]),
        .h_vis_i     (vis[0]),
        .v_vis_i     (vis[1]),
        .h_sync_i    (syn[0]),
        .v_sync_i    (syn[1]),
        .h_pol_i     (nxt_cfg[0].pol),
        .v_pol_i     (nxt_cfg[1].pol),
        .hsync       (hsync),
        .vsync       (vsync),
        .de          (de),
        .frame_start (frame_start),
        .pixel_x     (pixel_x),
        .line_y      (line_y)
    );

endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk
    import lcd_timing_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input lcd_cnt_t pixel_x,
    input lcd_cnt_t line_y,
    input logic     de,
    input logic     hsync,
    input logic     frame_start,
    input lcd_cfg_t act
);

    // R2: pixel position only moves forward by one, or back to zero
    a_r2_x_step: assert property (@(posedge clk) disable iff (rst)
        (pixel_x != '0) |-> (pixel_x == $past(pixel_x) + lcd_cnt_t'(1)));

    // R3: the line changes only where a line begins
    a_r3_y_at_x0: assert property (@(posedge clk) disable iff (rst)
        (line_y != $past(line_y)) |-> (pixel_x == '0));

    // R4: display enable only inside the displayed area
    a_r4_de_region: assert property (@(posedge clk) disable iff (rst)
        de |-> ((pixel_x < act.h.disp) && (line_y < act.v.disp)));

    // R5: horizontal sync never asserted before its start position
    a_r5_hs_region: assert property (@(posedge clk) disable iff (rst)
        (hsync == act.h.pol) |-> (pixel_x >= act.h.spos));

    // R9: the working timing changes only at the frame origin
    a_r9_cfg_at_frame: assert property (@(posedge clk) disable iff (rst)
        (act != $past(act)) |-> ((pixel_x == '0) && (line_y == '0)));

    // R10: frame start marks the origin
    a_r10_fs_origin: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> ((pixel_x == '0) && (line_y == '0)));

endmodule

bind lcd_sync_gen lcd_sync_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pixel_x     (pixel_x),
    .line_y      (line_y),
    .de          (de),
    .hsync       (hsync),
    .frame_start (frame_start),
    .act         (act_q)
);

// File: tb/tb_lcd_sync_gen.sv
module tb_lcd_sync_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [11:0] wr_data;
    logic        hsync, vsync, de, frame_start;
    logic [11:0] pixel_x, line_y;

    always #2 clk = ~clk;

    lcd_sync_gen dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .hsync       (hsync),
        .vsync       (vsync),
        .de          (de),
        .frame_start (frame_start),
        .pixel_x     (pixel_x),
        .line_y      (line_y)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // model of the timing the current frame runs on
    int ht = 20, hd = 12, hp = 15, hw = 3;
    int vt = 8,  vd = 5,  vp = 6,  vw = 1;
    bit hpl = 1'b0, vpl = 1'b0;

    // writes issued one per cycle during the next walked frame
    int pa [0:31];
    int pv [0:31];
    int pn = 0;
    int pi = 0;

    task automatic chk(string req, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic push_wr(int a, int d);
        pa[pn] = a;
        pv[pn] = d;
        pn++;
    endtask

    task automatic queue_cfg(int a_ht, int a_hd, int a_hp, int a_hw,
                             int a_vt, int a_vd, int a_vp, int a_vw, int pol);
        pn = 0;
        pi = 0;
        push_wr(0, a_ht); push_wr(1, a_hd); push_wr(2, a_hp); push_wr(3, a_hw);
        push_wr(4, a_vt); push_wr(5, a_vd); push_wr(6, a_vp); push_wr(7, a_vw);
        push_wr(8, pol);
    endtask

    task automatic set_model(int a_ht, int a_hd, int a_hp, int a_hw,
                             int a_vt, int a_vd, int a_vp, int a_vw, int pol);
        ht = a_ht; hd = a_hd; hp = a_hp; hw = a_hw;
        vt = a_vt; vd = a_vd; vp = a_vp; vw = a_vw;
        hpl = pol[0]; vpl = pol[1];
    endtask

    // walk one whole frame at falling edges, checking every output
    task automatic walk_frame(string rx, string ry, string rde,
                              string rhs, string rvs, string rfs);
        int guard = 0;
        while (frame_start !== 1'b1 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(rfs, "frame start seen", int'(frame_start), 1);
        for (int i = 0; i < ht * vt; i++) begin
            int x;
            int y;
            bit ha;
            bit va;
            x  = i % ht;
            y  = i / ht;
            ha = (x >= hp) && (x - hp < hw);
            va = (y >= vp) && (y - vp < vw);
            chk(rx,  "pixel_x",     int'(pixel_x), x);
            chk(ry,  "line_y",      int'(line_y),  y);
            chk(rde, "de",          int'(de),      int'((x < hd) && (y < vd)));
            chk(rhs, "hsync",       int'(hsync),   int'(hpl ? ha : !ha));
            chk(rvs, "vsync",       int'(vsync),   int'(vpl ? va : !va));
            chk(rfs, "frame_start", int'(frame_start), int'(x == 0 && y == 0));
            if (pi < pn) begin
                wr_en   = 1'b1;
                wr_addr = 4'(pa[pi]);
                wr_data = 12'(pv[pi]);
                pi++;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        chk("R1", "pixel_x", int'(pixel_x), 0);
        chk("R1", "line_y",  int'(line_y), 0);
        chk("R1", "de",      int'(de), 0);
        chk("R1", "frame_start", int'(frame_start), 0);
        chk("R1", "hsync",   int'(hsync), 1);
        chk("R1", "vsync",   int'(vsync), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "first frame_start after reset", int'(frame_start), 1);
    endtask

    task automatic t_default_frame();
        walk_frame("R2", "R3", "R4", "R5", "R6", "R10");
    endtask

    task automatic t_shadow_update();
        // new timing written during a frame: the frame keeps the old timing
        queue_cfg(16, 10, 12, 2, 6, 4, 4, 0, 3);
        walk_frame("R9", "R9", "R9", "R9", "R9", "R9");
        set_model(16, 10, 12, 2, 6, 4, 4, 0, 3);
        // active-high polarity, vertical width 0 gives no pulse
        walk_frame("R2", "R3", "R4", "R8", "R6", "R10");
    endtask

    task automatic t_truncation();
        queue_cfg(10, 6, 8, 5, 5, 3, 4, 3, 0);
        walk_frame("R9", "R9", "R9", "R8", "R8", "R9");
        set_model(10, 6, 8, 5, 5, 3, 4, 3, 0);
        walk_frame("R2", "R3", "R4", "R7", "R7", "R10");
    endtask

    task automatic t_unused_addr();
        pn = 0;
        pi = 0;
        push_wr(9, 1);
        push_wr(12, 0);
        push_wr(15, 0);
        walk_frame("R11", "R11", "R11", "R11", "R11", "R11");
        walk_frame("R11", "R11", "R11", "R11", "R11", "R11");
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_default_frame();
        t_shadow_update();
        t_truncation();
        t_unused_addr();
        finish_run();
    end

endmodule